// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The controller gathers a parameterized set of interrupt inputs and presents one interrupt line to a single processor. Each input has a configuration word that holds a mask, an input polarity, a choice of level or edge sensing, a 4-bit priority and an 8-bit vector. Each input also has a routing word whose bit 0 sends the input to the processor. The processor side offers a 4-bit task priority, an acknowledge register and an end-of-interrupt register. Reading the acknowledge register claims the most urgent deliverable input and returns its vector. End-of-interrupt retires the most urgent level in service. All registers sit on a simple 32-bit read/write bus. Read data is registered and appears one cycle after the read strobe.

Arbitration looks at every unmasked, routed, pending input. The highest priority wins, and on a tie the lowest input index wins. The winner is deliverable only if its priority is strictly above both the task priority and the most urgent priority already in service. A small state machine drives the interrupt line. It has three states. In ST_IDLE the line is low. ST_IDLE goes to ST_RAISED when a source is deliverable. In ST_RAISED the line is high. ST_RAISED goes to ST_IDLE when nothing is deliverable. A successful acknowledge, from any state, goes to ST_CLAIMED. ST_CLAIMED lasts one cycle with the line low, then goes to ST_RAISED if a source is still deliverable, otherwise to ST_IDLE.

Top module: `pic_ctrl`

## Requirements
- R1: After reset every configuration word reads 0x8000_0000 (masked, all other fields zero). Every routing word reads 0, the task priority reads 15, the global configuration word reads 0, `irq_o` is low and an acknowledge read returns 0xFF.
- R2: Address 0x01000 reads the version parameter in bits 7:0, the last processor index (0) in bits 12:8 and NSRC-1 in bits 26:16. All other bits read 0.
- R3: The configuration word of source n is at 0x10000 + n*0x20. Its fields are: mask bit 31, activity bit 30 (read-only), polarity bit 23 (1 = active-high), sense bit 22 (1 = level, 0 = edge), priority bits 19:16 and vector bits 7:0. All other bits read 0. The routing word is at 0x10010 + n*0x20, bit 0 only. Read data appears on the cycle after the read.
- R4: A level-sensed source is pending exactly while its input is at the active level, so it is delivered again after end-of-interrupt if the input is still active.
- R5: An edge-sensed source latches pending on an inactive-to-active change of its input. The latch holds after the input returns to inactive and is cleared only when that source is acknowledged.
- R6: A source is deliverable only if it is unmasked, its routing bit 0 is set, and its priority is strictly greater than both the task priority and the highest priority in service.
- R7: Among deliverable candidates the highest priority wins. Equal priorities resolve to the lowest source index.
- R8: A read of 0x200A0 returns the winner's vector in bits 7:0, with zeros above, and marks its priority level as in service. If nothing is deliverable it returns 0xFF and changes no state.
- R9: A write of any value to 0x200B0 retires the highest priority level in service. With nothing in service it has no effect.
- R10: The activity bit reads 1 while the source is pending (even if masked) or in service, and 0 otherwise.
- R11: `irq_o` rises on the cycle after the first cycle in which a source is deliverable. It falls on the cycle after nothing is deliverable, and it is low on the cycle after a successful acknowledge.
- R12: The task priority register at 0x20080 holds bits 3:0. Its upper bits read 0.
- R13: The global configuration word at 0x01020 stores bits 31 and 29. All its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Interrupt source inputs, synchronous to clk |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 18 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A table of source pairs is driven against the arbiter. The table varies the priorities and the task priority so that four outcomes can be told apart: a plain higher-priority win, a tie broken by index, a block at equal task priority (strict comparison), and a pass one step above it. Separate sequences cover the other behaviours. One pulses an edge source once, which separates a latched edge from a level that has dropped. One holds an active-low level through end-of-interrupt, which shows re-delivery from the level itself. One nests three priorities, which shows preemption by a higher level and the blocking of a lower one until the in-service level is retired. Routing and masking are toggled on a held input to show that each one gates delivery while the activity bit still reports the pending input.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int PRIO_W  = 4;
    localparam int LEVELS  = 1 << PRIO_W;
    localparam int ADDR_W  = 18;

    localparam logic [7:0] SPURIOUS_VEC = 8'hFF;

    localparam logic [ADDR_W-1:0] A_FEATURE = 18'h01000;
    localparam logic [ADDR_W-1:0] A_GCONF   = 18'h01020;
    localparam logic [ADDR_W-1:0] A_TASKPRI = 18'h20080;
    localparam logic [ADDR_W-1:0] A_ACK     = 18'h200A0;
    localparam logic [ADDR_W-1:0] A_EOI     = 18'h200B0;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RAISED  = 2'd1,
        ST_CLAIMED = 2'd2
    } irq_state_e;

    typedef struct packed {
        logic              mask;
        logic              pol;
        logic              level;
        logic [PRIO_W-1:0] prio;
        logic [7:0]        vec;
    } src_cfg_t;

    localparam src_cfg_t CFG_RST = '{mask: 1'b1, pol: 1'b0, level: 1'b0,
                                     prio: '0, vec: '0};
endpackage

// File: rtl/pic_source.sv
module pic_source
    import pic_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     irq_in,
    input  logic     cfg_we,
    input  logic     dest_we,
    input  logic [31:0] wdata,
    input  logic     ack_take,
    input  logic     svc_clear,
    output src_cfg_t cfg,
    output logic     dest,
    output logic     pending,
    output logic     in_service,
    output logic     req
);
    logic smp_q;
    logic edge_q;
    logic active_now;
    logic active_smp;
    logic edge_set;

    assign active_now = cfg.pol ? irq_in : ~irq_in;
    assign active_smp = cfg.pol ? smp_q  : ~smp_q;
    assign edge_set   = ~cfg.level & active_now & ~active_smp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg        <= CFG_RST;
            dest       <= 1'b0;
            smp_q      <= 1'b0;
            edge_q     <= 1'b0;
            in_service <= 1'b0;
        end else begin
            smp_q <= irq_in;
            if (cfg_we) begin
                cfg.mask  <= wdata[31];
                cfg.pol   <= wdata[23];
                cfg.level <= wdata[22];
                cfg.prio  <= wdata[16 +: PRIO_W];
                cfg.vec   <= wdata[7:0];
            end
            if (dest_we) begin
                dest <= wdata[0];
            end
            if (edge_set) begin
                edge_q <= 1'b1;
            end else if (ack_take) begin
                edge_q <= 1'b0;
            end
            if (ack_take) begin
                in_service <= 1'b1;
            end else if (svc_clear) begin
                in_service <= 1'b0;
            end
        end
    end

    assign pending = cfg.level ? active_smp : edge_q;
    assign req     = pending & ~cfg.mask & dest;
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int N     = 32,
    parameter int IDX_W = 5
) (
    input  logic              req  [N],
    input  logic [PRIO_W-1:0] prio [N],
    output logic              any,
    output logic [IDX_W-1:0]  win_idx,
    output logic [PRIO_W-1:0] win_prio
);
    always_comb begin
        any      = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!any || prio[i] > win_prio)) begin
                any      = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = prio[i];
            end
        end
    end
endmodule

// File: rtl/pic_inservice.sv
module pic_inservice
    import pic_pkg::*;
#(
    parameter int N     = 32,
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_lvl,
    input  logic [IDX_W-1:0]  push_idx,
    input  logic              pop,
    output logic [PRIO_W-1:0] top_lvl,
    output logic [N-1:0]      svc_clr
);
    logic [LEVELS-1:0] active_q;
    logic [IDX_W-1:0]  owner_q [LEVELS];
    logic              pop_ok;

    always_comb begin
        top_lvl = '0;
        for (int l = 0; l < LEVELS; l++) begin
            if (active_q[l]) begin
                top_lvl = PRIO_W'(l);
            end
        end
    end

    assign pop_ok = pop && (|active_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= '0;
            for (int l = 0; l < LEVELS; l++) begin
                owner_q[l] <= '0;
            end
        end else if (push) begin
            active_q[push_lvl] <= 1'b1;
            owner_q[push_lvl]  <= push_idx;
        end else if (pop_ok) begin
            active_q[top_lvl] <= 1'b0;
        end
    end

    for (genvar n = 0; n < N; n++) begin : g_clr
        assign svc_clr[n] = pop_ok && (owner_q[top_lvl] == IDX_W'(n));
    end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
#(
    parameter int         NSRC    = 32,
    parameter logic [7:0] VERSION = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    localparam int          IDX_W  = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam logic [10:0] NSRC_L = 11'(NSRC);
    localparam logic [10:0] LAST_L = 11'(NSRC - 1);

    // decode
    logic        src_region, src_ok, vp_hit, dest_hit;
    logic [10:0] sel_idx;
    logic [IDX_W-1:0] sel;

    assign src_region = (bus_addr[17:16] == 2'b01);
    assign sel_idx    = bus_addr[15:5];
    assign sel        = sel_idx[IDX_W-1:0];
    assign src_ok     = src_region && (sel_idx < NSRC_L);
    assign vp_hit     = src_ok && (bus_addr[4:0] == 5'h00);
    assign dest_hit   = src_ok && (bus_addr[4:0] == 5'h10);

    // per-source state
    src_cfg_t          cfg_v  [NSRC];
    logic              req_v  [NSRC];
    logic [PRIO_W-1:0] prio_v [NSRC];
    logic [NSRC-1:0]   dest_v, pend_v, insvc_v, ack_take, svc_clr;

    logic              arb_any, deliver, ack_rd, grant, eoi_wr;
    logic [IDX_W-1:0]  arb_idx;
    logic [PRIO_W-1:0] arb_prio, isr_top;

    for (genvar n = 0; n < NSRC; n++) begin : g_src
        logic req_n;
        pic_source u_src (
            .clk        (clk),
            .rst_n      (rst_n),
            .irq_in     (src_i[n]),
            .cfg_we     (bus_wr && vp_hit && (sel_idx == 11'(n))),
            .dest_we    (bus_wr && dest_hit && (sel_idx == 11'(n))),
            .wdata      (bus_wdata),
            .ack_take   (ack_take[n]),
            .svc_clear  (svc_clr[n]),
            .cfg        (cfg_v[n]),
            .dest       (dest_v[n]),
            .pending    (pend_v[n]),
            .in_service (insvc_v[n]),
            .req        (req_n)
        );
        assign req_v[n]    = req_n;
        assign prio_v[n]   = cfg_v[n].prio;
        assign ack_take[n] = grant && (arb_idx == IDX_W'(n));
    end

    pic_arbiter #(.N(NSRC), .IDX_W(IDX_W)) u_arb (
        .req      (req_v),
        .prio     (prio_v),
        .any      (arb_any),
        .win_idx  (arb_idx),
        .win_prio (arb_prio)
    );

    // processor-side registers
    logic [PRIO_W-1:0] task_pri_q;
    logic              gc_rst_q, gc_pt_q;

    assign deliver = arb_any && (arb_prio > task_pri_q) && (arb_prio > isr_top);
    assign ack_rd  = bus_rd && (bus_addr == A_ACK);
    assign grant   = ack_rd && deliver;
    assign eoi_wr  = bus_wr && (bus_addr == A_EOI);

    pic_inservice #(.N(NSRC), .IDX_W(IDX_W)) u_isr (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (grant),
        .push_lvl (arb_prio),
        .push_idx (arb_idx),
        .pop      (eoi_wr),
        .top_lvl  (isr_top),
        .svc_clr  (svc_clr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            task_pri_q <= '1;
            gc_rst_q   <= 1'b0;
            gc_pt_q    <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == A_TASKPRI) begin
                task_pri_q <= bus_wdata[PRIO_W-1:0];
            end
            if (bus_addr == A_GCONF) begin
                gc_rst_q <= bus_wdata[31];
                gc_pt_q  <= bus_wdata[29];
            end
        end
    end

    // interrupt line state machine
    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (grant) begin
            state_d = ST_CLAIMED;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = deliver ? ST_RAISED : ST_IDLE;
                ST_RAISED:  state_d = deliver ? ST_RAISED : ST_IDLE;
                ST_CLAIMED: state_d = deliver ? ST_RAISED : ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        irq_o = (state_q == ST_RAISED);
    end

    // read path
    logic [31:0] rd_val;
    src_cfg_t    sel_cfg;

    assign sel_cfg = cfg_v[sel];

    always_comb begin
        rd_val = '0;
        if (bus_addr == A_FEATURE) begin
            rd_val = {5'd0, LAST_L, 3'd0, 5'd0, VERSION};
        end else if (bus_addr == A_GCONF) begin
            rd_val = {gc_rst_q, 1'b0, gc_pt_q, 29'd0};
        end else if (bus_addr == A_TASKPRI) begin
            rd_val = {{(32-PRIO_W){1'b0}}, task_pri_q};
        end else if (bus_addr == A_ACK) begin
            rd_val = {24'd0, deliver ? cfg_v[arb_idx].vec : SPURIOUS_VEC};
        end else if (vp_hit) begin
            rd_val = {sel_cfg.mask, pend_v[sel] | insvc_v[sel], 6'd0,
                      sel_cfg.pol, sel_cfg.level, 2'd0, sel_cfg.prio,
                      8'd0, sel_cfg.vec};
        end else if (dest_hit) begin
            rd_val = {31'd0, dest_v[sel]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_val;
        end
    end
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk
    import pic_pkg::*;
#(
    parameter int NSRC = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_o,
    input logic              deliver,
    input logic              grant,
    input logic              ack_rd,
    input logic              eoi_wr,
    input logic [31:0]       bus_rdata,
    input logic [PRIO_W-1:0] isr_top,
    input logic [PRIO_W-1:0] arb_prio,
    input logic [NSRC-1:0]   ack_take
);
    p_irq_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(deliver));

    p_irq_low_after_claim_r11: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !irq_o);

    p_spurious_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !deliver) |=> (bus_rdata == 32'h0000_00FF));

    p_claim_pushes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> (isr_top == $past(arb_prio)));

    p_single_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_take));

    p_eoi_lowers_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && isr_top != '0) |=> (isr_top < $past(isr_top)));
endmodule

bind pic_ctrl pic_ctrl_chk #(.NSRC(NSRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_o     (irq_o),
    .deliver   (deliver),
    .grant     (grant),
    .ack_rd    (ack_rd),
    .eoi_wr    (eoi_wr),
    .bus_rdata (bus_rdata),
    .isr_top   (isr_top),
    .arb_prio  (arb_prio),
    .ack_take  (ack_take)
);

// File: tb/pic_ctrl_tb_top.sv
`timescale 1ns/1ps
module pic_ctrl_tb_top;
    localparam int NSRC = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NSRC-1:0]  src_i = '0;
    logic             bus_rd = 1'b0;
    logic             bus_wr = 1'b0;
    logic [17:0]      bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic             irq_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    pic_ctrl #(.NSRC(NSRC), .VERSION(8'h02)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    localparam logic [17:0] FEAT = 18'h01000, GCONF = 18'h01020,
        TPRI = 18'h20080, ACK = 18'h200A0, EOI = 18'h200B0;

    function automatic logic [17:0] vp_a(input int n);
        return 18'(32'h10000 + n * 32'h20);
    endfunction
    function automatic logic [17:0] dst_a(input int n);
        return 18'(32'h10010 + n * 32'h20);
    endfunction
    // level, active-high, unmasked
    function automatic logic [31:0] lvl_word(input int p, input int v);
        return 32'h00C0_0000 | (32'(p) << 16) | 32'(v);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [17:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [17:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    typedef struct packed {
        logic [4:0] a;
        logic [3:0] pa;
        logic [4:0] b;
        logic [3:0] pb;
        logic [3:0] tp;
        logic [7:0] exp;
    } arb_vec_t;

    // vector of source n is 0x40+n
    localparam arb_vec_t TBL [6] = '{
        '{5'd3, 4'd5, 5'd9,  4'd7,  4'd0,  8'h49},
        '{5'd3, 4'd7, 5'd9,  4'd7,  4'd0,  8'h43},
        '{5'd3, 4'd5, 5'd9,  4'd4,  4'd6,  8'hFF},
        '{5'd3, 4'd5, 5'd9,  4'd4,  4'd4,  8'h43},
        '{5'd3, 4'd5, 5'd9,  4'd4,  4'd5,  8'hFF},
        '{5'd0, 4'd1, 5'd31, 4'd15, 4'd14, 8'h5F}
    };

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        chk("R1 irq after reset", 32'(irq_o), 32'd0);
        rd(vp_a(0), rv);  chk("R1 source 0 config", rv, 32'h8000_0000);
        rd(vp_a(31), rv); chk("R1 source 31 config", rv, 32'h8000_0000);
        rd(dst_a(0), rv); chk("R1 routing", rv, 32'd0);
        rd(TPRI, rv);     chk("R1 task priority", rv, 32'd15);
        rd(GCONF, rv);    chk("R1 global config", rv, 32'd0);
        rd(ACK, rv);      chk("R1 acknowledge", rv, 32'hFF);

        // R2 feature word
        rd(FEAT, rv); chk("R2 feature", rv, 32'h001F_0002);

        // R13 global config
        wr(GCONF, 32'hFFFF_FFFF); rd(GCONF, rv); chk("R13 config set", rv, 32'hA000_0000);
        wr(GCONF, 32'h0000_0000); rd(GCONF, rv); chk("R13 config clear", rv, 32'd0);

        // R12 task priority width
        wr(TPRI, 32'hFFFF_FFF7); rd(TPRI, rv); chk("R12 task priority", rv, 32'd7);
        wr(TPRI, 32'd0);         rd(TPRI, rv); chk("R12 task priority zero", rv, 32'd0);

        // R3 field layout
        wr(vp_a(1), 32'hFFFF_FFFF); rd(vp_a(1), rv); chk("R3 config fields", rv, 32'h80CF_00FF);
        wr(dst_a(1), 32'hFFFF_FFFF); rd(dst_a(1), rv); chk("R3 routing bit", rv, 32'd1);
        wr(vp_a(1), 32'h8000_0000); wr(dst_a(1), 32'd0);

        // table-driven arbitration: R6, R7, R8, R11
        for (int k = 0; k < 6; k++) begin
            wr(dst_a(TBL[k].a), 32'd1);
            wr(dst_a(TBL[k].b), 32'd1);
            wr(vp_a(TBL[k].a), lvl_word(TBL[k].pa, 32'h40 + TBL[k].a));
            wr(vp_a(TBL[k].b), lvl_word(TBL[k].pb, 32'h40 + TBL[k].b));
            wr(TPRI, 32'(TBL[k].tp));
            src_i[TBL[k].a] = 1'b1;
            src_i[TBL[k].b] = 1'b1;
            wait_cyc(2);
            chk($sformatf("R11 irq row %0d", k), 32'(irq_o), 32'(TBL[k].exp != 8'hFF));
            rd(ACK, rv);
            chk($sformatf("R7 R6 winner row %0d", k), rv, 32'(TBL[k].exp));
            if (TBL[k].exp != 8'hFF) begin
                chk($sformatf("R11 irq low after claim row %0d", k), 32'(irq_o), 32'd0);
                wr(EOI, 32'h1234);
            end
            src_i[TBL[k].a] = 1'b0;
            src_i[TBL[k].b] = 1'b0;
            wr(vp_a(TBL[k].a), 32'h8000_0000);
            wr(vp_a(TBL[k].b), 32'h8000_0000);
        end
        wr(TPRI, 32'd0);

        // R5 edge sense, R10 activity
        wr(dst_a(5), 32'd1);
        wr(vp_a(5), 32'h0083_0045);
        @(negedge clk); src_i[5] = 1'b1;
        @(negedge clk); src_i[5] = 1'b0;
        wait_cyc(2);
        chk("R5 edge latched irq", 32'(irq_o), 32'd1);
        rd(vp_a(5), rv); chk("R10 activity while pending", rv, 32'h4083_0045);
        rd(ACK, rv); chk("R5 edge vector", rv, 32'h45);
        chk("R11 low after claim", 32'(irq_o), 32'd0);
        rd(vp_a(5), rv); chk("R10 activity in service", rv, 32'h4083_0045);
        wr(EOI, 32'd0);
        rd(ACK, rv); chk("R5 edge cleared by ack", rv, 32'hFF);
        rd(vp_a(5), rv); chk("R10 activity idle", rv, 32'h0083_0045);
        wr(vp_a(5), 32'h8000_0000);

        // R4 level, active-low
        src_i[7] = 1'b1;
        wr(dst_a(7), 32'd1);
        wr(vp_a(7), 32'h0042_0047);
        wait_cyc(2);
        chk("R4 inactive level", 32'(irq_o), 32'd0);
        src_i[7] = 1'b0;
        wait_cyc(2);
        chk("R4 active-low irq", 32'(irq_o), 32'd1);
        rd(ACK, rv); chk("R4 vector", rv, 32'h47);
        wr(EOI, 32'd0);
        rd(ACK, rv); chk("R4 redelivered while held", rv, 32'h47);
        wr(EOI, 32'd0);
        src_i[7] = 1'b1;
        wait_cyc(1);
        rd(ACK, rv); chk("R4 released", rv, 32'hFF);
        wr(vp_a(7), 32'h8000_0000);

        // nesting R6, R9
        for (int s = 10; s <= 12; s++) wr(dst_a(s), 32'd1);
        wr(vp_a(10), lvl_word(4, 32'h4A));
        wr(vp_a(11), lvl_word(9, 32'h4B));
        wr(vp_a(12), lvl_word(6, 32'h4C));
        src_i[10] = 1'b1;
        wait_cyc(1);
        rd(ACK, rv); chk("R8 first claim", rv, 32'h4A);
        src_i[11] = 1'b1;
        wait_cyc(2);
        chk("R6 preempt above in service", 32'(irq_o), 32'd1);
        rd(ACK, rv); chk("R8 nested claim", rv, 32'h4B);
        src_i[11] = 1'b0;
        src_i[12] = 1'b1;
        wait_cyc(2);
        chk("R6 blocked below in service", 32'(irq_o), 32'd0);
        rd(ACK, rv); chk("R6 blocked claim", rv, 32'hFF);
        wr(EOI, 32'd0);
        rd(ACK, rv); chk("R9 retire unblocks", rv, 32'h4C);
        src_i[12] = 1'b0;
        src_i[10] = 1'b0;
        wr(EOI, 32'd0);
        rd(vp_a(10), rv); chk("R10 in service, input low", rv, 32'h40C4_004A);
        wr(EOI, 32'd0);
        rd(vp_a(10), rv); chk("R9 last level retired", rv, 32'h00C4_004A);
        wr(EOI, 32'd0);
        rd(ACK, rv); chk("R9 empty retire no effect", rv, 32'hFF);
        for (int s = 10; s <= 12; s++) wr(vp_a(s), 32'h8000_0000);

        // routing and mask R6, R10
        wr(vp_a(20), lvl_word(5, 32'h54));
        src_i[20] = 1'b1;
        wait_cyc(2);
        chk("R6 unrouted no irq", 32'(irq_o), 32'd0);
        rd(ACK, rv); chk("R6 unrouted claim", rv, 32'hFF);
        wr(dst_a(20), 32'd1);
        wait_cyc(1);
        chk("R6 routed irq", 32'(irq_o), 32'd1);
        rd(ACK, rv); chk("R6 routed claim", rv, 32'h54);
        wr(EOI, 32'd0);
        wr(vp_a(20), 32'h80C5_0054);
        wait_cyc(1);
        chk("R6 masked no irq", 32'(irq_o), 32'd0);
        rd(ACK, rv); chk("R6 masked claim", rv, 32'hFF);
        rd(vp_a(20), rv); chk("R10 masked but pending", rv, 32'hC0C5_0054);
        src_i[20] = 1'b0;
        wait_cyc(2);
        chk("R11 line stays low", 32'(irq_o), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule